// File: doc/BRIEF.md
# Selectable Bipolar Line Codec

This block sits between a DS3/E3 framer and a line interface unit. On the transmit side it turns a serial bit stream, qualified by a clock enable, into positive and negative rail pulses. On the receive side it turns rail pulses back into data bits and emits a single-clock pulse for an external line-code-violation counter. Three line codes share the one datapath. The first is bipolar signalling with zero substitution: three-zero substitution for DS3 or four-zero substitution for E3, chosen by the `HDB3` parameter. The second is plain alternate mark inversion. The third is a unipolar NRZ bypass.

Each direction delays its data by a fixed window of `RUN` symbols, where `RUN` is 4 with `HDB3=1` and 3 otherwise. This window lets the transmitter rewrite a run of zeros after it has seen the whole run, and lets the receiver remove a substitution after the violation pulse that marks it has arrived. The NRZ setting overrides both AMI settings. It also changes what the negative receive rail means: in NRZ the line interface drives that rail as its own violation-count input. The NRZ setting is static configuration and changes only while the link is idle. The two AMI settings may change at any time.

Top module: `bipolar_line_codec`

## Requirements
- R1: In both bipolar modes the transmit rails are never high together. A positive pulse is `tx_pos=1, tx_neg=0` and a negative pulse is `tx_pos=0, tx_neg=1`. Each data mark is sent with the opposite polarity to the previous pulse. The first mark after reset is positive.
- R2: With `cfg_tx_ami=0` and `cfg_nrz=0`, every run of `RUN` zeros is replaced by a substitution. If an odd number of marks has been sent since the last substitution, the run becomes zeros followed by V. If the count is even, the run becomes B, then zeros, then V. B takes the opposite polarity to the previous pulse. V takes the same polarity as the previous pulse. The mark count is cleared after each substitution. Reset leaves the count even and treats the window as already holding `RUN-1` zeros.
- R3: With `cfg_tx_ami=1` and `cfg_nrz=0`, zeros are sent as no pulse and no substitution takes place.
- R4: With `cfg_nrz=1`, `tx_pos` carries the data bit, `tx_neg` stays low, and `cfg_tx_ami` has no effect.
- R5: With `cfg_nrz=1`, `rx_data` is taken from `rx_pos`. `rx_lcv_inc` equals `rx_neg` as sampled on the previous clock whenever `rx_en` was high on that clock. `cfg_rx_ami` has no effect.
- R6: With `cfg_rx_ami=0` and `cfg_nrz=0`, a V is a pulse with the same polarity as the previous pulse. When a V arrives and the `RUN-2` bit periods just before it held no pulse, the V and the `RUN-1` periods before it are all decoded as zeros, and no violation is raised.
- R7: With `cfg_rx_ami=1` and `cfg_nrz=0`, every pulse with the same polarity as the previous pulse is decoded as a 1 and raises a violation.
- R8: In bipolar modes, pulses on both receive rails at once decode as a 1 and raise a violation. A same-polarity pulse that does not form a valid substitution also raises a violation. `rx_lcv_inc` is high for one clock per offending enabled symbol. The first pulse after reset never raises a violation.
- R9: A bit accepted on the k-th `tx_en` appears on the rails on the clock of the (k+`RUN`)-th `tx_en`. The receive path has the same latency, counted in `rx_en` cycles. Outputs hold their value between enables.
- R10: While reset is active, and until the first enable after it, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_tx_ami | input | 1 | Transmit plain AMI (no substitution) |
| cfg_rx_ami | input | 1 | Receive plain AMI (no substitution removal) |
| cfg_nrz | input | 1 | Unipolar NRZ bypass for both directions, static |
| tx_en | input | 1 | Transmit symbol enable |
| tx_data | input | 1 | Transmit data bit |
| tx_pos | output | 1 | Positive transmit rail |
| tx_neg | output | 1 | Negative transmit rail |
| rx_en | input | 1 | Receive symbol enable |
| rx_pos | input | 1 | Positive receive rail (NRZ data in NRZ mode) |
| rx_neg | input | 1 | Negative receive rail (external violation input in NRZ mode) |
| rx_data | output | 1 | Decoded data bit |
| rx_lcv_inc | output | 1 | One-clock line-code-violation increment |

## Verification
The assertions run on every cycle. They check that the transmit rails are never both high and that the negative transmit rail stays low in NRZ mode. They check that both outputs hold while their enable is low. They also check that a dual-rail receive pulse always raises the violation flag, that the flag in NRZ mode follows the negative rail, and that the first pulse after reset is never flagged. Some behaviours need the history of the stream, and only the bench scenarios can show them. These are the B-versus-V choice set by the mark-count parity, the polarity of B and V pulses, the removal of a substitution on receive, and the split between valid substitutions and true violations in substitution and AMI receive modes. The bench compares these against a queue-based model over loopback, injected errors and enables with gaps.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_MARK  = 2'd1,
    SYM_BAL   = 2'd2,
    SYM_VIO   = 2'd3
  } sym_e;
endpackage

// File: rtl/blc_encoder.sv
module blc_encoder
  import blc_pkg::*;
#(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ami,
  input  logic cfg_nrz,
  input  logic bit_en,
  input  logic bit_in,
  output logic pos_o,
  output logic neg_o
);
  sym_e pipe_q [RUN];
  sym_e pipe_d [RUN];
  sym_e head;
  logic odd_q, odd_d;
  logic last_q, last_d;
  logic pos_q, pos_d, neg_q, neg_d;
  logic zero_run, do_sub;

  always_comb begin
    zero_run = 1'b1;
    for (int i = 0; i < RUN - 1; i++) begin
      if (pipe_q[i] != SYM_SPACE) zero_run = 1'b0;
    end
    do_sub = !cfg_nrz && !cfg_ami && !bit_in && zero_run;
    head   = pipe_q[RUN-1];
    pipe_d = pipe_q;
    odd_d  = odd_q;
    last_d = last_q;
    pos_d  = pos_q;
    neg_d  = neg_q;
    if (bit_en) begin
      pipe_d[0] = bit_in ? SYM_MARK : SYM_SPACE;
      for (int i = 1; i < RUN; i++) pipe_d[i] = pipe_q[i-1];
      odd_d = odd_q ^ bit_in;
      if (do_sub) begin
        pipe_d[0]     = SYM_VIO;
        pipe_d[RUN-1] = odd_q ? SYM_SPACE : SYM_BAL;
        odd_d         = 1'b0;
      end
      if (cfg_nrz) begin
        pos_d = (head != SYM_SPACE);
        neg_d = 1'b0;
      end else begin
        case (head)
          SYM_SPACE: begin pos_d = 1'b0;    neg_d = 1'b0;   end
          SYM_VIO:   begin pos_d = last_q;  neg_d = !last_q; end
          default:   begin pos_d = !last_q; neg_d = last_q; last_d = !last_q; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RUN; i++) pipe_q[i] <= SYM_SPACE;
      odd_q  <= 1'b0;
      last_q <= 1'b0;
      pos_q  <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      odd_q  <= odd_d;
      last_q <= last_d;
      pos_q  <= pos_d;
      neg_q  <= neg_d;
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q;

  AST_TX_RAILS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_q && neg_q)); // R1
  AST_NRZ_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && cfg_nrz) |=> !neg_q); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(pos_q) && $stable(neg_q))); // R9
endmodule

// File: rtl/blc_decoder.sv
module blc_decoder #(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ami,
  input  logic cfg_nrz,
  input  logic sym_en,
  input  logic pos_i,
  input  logic neg_i,
  output logic data_o,
  output logic lcv_o
);
  logic [RUN-1:0] bits_q, bits_d;
  logic last_q, last_d, seen_q, seen_d;
  logic data_q, data_d, lcv_q, lcv_d;
  logic both, pulse, repeat_pol, quiet, sub_hit;

  always_comb begin
    both       = pos_i & neg_i;
    pulse      = pos_i ^ neg_i;
    repeat_pol = pulse && seen_q && (pos_i == last_q);
    quiet      = 1'b1;
    for (int i = 0; i < RUN - 2; i++) begin
      if (bits_q[i]) quiet = 1'b0;
    end
    sub_hit = !cfg_nrz && !cfg_ami && repeat_pol && quiet;
    bits_d  = bits_q;
    last_d  = last_q;
    seen_d  = seen_q;
    data_d  = data_q;
    lcv_d   = 1'b0;
    if (sym_en) begin
      data_d = bits_q[RUN-1];
      if (cfg_nrz) begin
        bits_d = {bits_q[RUN-2:0], pos_i};
        lcv_d  = neg_i;
      end else begin
        bits_d = {bits_q[RUN-2:0], pos_i | neg_i};
        lcv_d  = both || (repeat_pol && !sub_hit);
        if (sub_hit) bits_d = '0;
        if (pulse) begin
          last_d = pos_i;
          seen_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
      data_q <= 1'b0;
      lcv_q  <= 1'b0;
    end else begin
      bits_q <= bits_d;
      last_q <= last_d;
      seen_q <= seen_d;
      data_q <= data_d;
      lcv_q  <= lcv_d;
    end
  end

  assign data_o = data_q;
  assign lcv_o  = lcv_q;

  AST_BOTH_RAILS_LCV: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && !cfg_nrz && pos_i && neg_i) |=> lcv_q); // R8
  AST_LCV_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    lcv_q |-> $past(sym_en)); // R8
  AST_FIRST_PULSE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && !cfg_nrz && !seen_q && (pos_i ^ neg_i)) |=> !lcv_q); // R8
  AST_NRZ_LCV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && cfg_nrz) |=> (lcv_q == $past(neg_i))); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> $stable(data_q)); // R9
endmodule

// File: rtl/bipolar_line_codec.sv
module bipolar_line_codec #(
  parameter bit HDB3 = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_tx_ami,
  input  logic cfg_rx_ami,
  input  logic cfg_nrz,
  input  logic tx_en,
  input  logic tx_data,
  output logic tx_pos,
  output logic tx_neg,
  input  logic rx_en,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic rx_data,
  output logic rx_lcv_inc
);
  localparam int RUN = HDB3 ? 4 : 3;

  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  blc_encoder #(.RUN(RUN)) u_enc (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .cfg_ami(cfg_tx_ami),
    .cfg_nrz(cfg_nrz),
    .bit_en (tx_en),
    .bit_in (tx_data),
    .pos_o  (tx_pos),
    .neg_o  (tx_neg)
  );

  blc_decoder #(.RUN(RUN)) u_dec (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .cfg_ami(cfg_rx_ami),
    .cfg_nrz(cfg_nrz),
    .sym_en (rx_en),
    .pos_i  (rx_pos),
    .neg_i  (rx_neg),
    .data_o (rx_data),
    .lcv_o  (rx_lcv_inc)
  );
endmodule

// File: tb/sim_bipolar_line_codec.sv
module sim_bipolar_line_codec;
  localparam int RUN = 4;

  logic clk = 1'b0;
  logic rst_n, cfg_tx_ami, cfg_rx_ami, cfg_nrz;
  logic tx_en, tx_data, rx_en, rx_pos, rx_neg;
  logic tx_pos, tx_neg, rx_data, rx_lcv_inc;

  always #4 clk = ~clk;

  bipolar_line_codec #(.HDB3(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tx_ami(cfg_tx_ami), .cfg_rx_ami(cfg_rx_ami),
    .cfg_nrz(cfg_nrz), .tx_en(tx_en), .tx_data(tx_data), .tx_pos(tx_pos),
    .tx_neg(tx_neg), .rx_en(rx_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .rx_data(rx_data), .rx_lcv_inc(rx_lcv_inc)
  );

  int tests = 0;
  int fails = 0;
  string tag = "R10";
  int unsigned seed = 32'h1234_5678;

  // transmit model: 0 space, 1 mark, 2 B, 3 V
  int sq[$];
  int zc;
  bit par, tlast, exp_tp, exp_tn;
  // receive model
  bit dq[$];
  bit rseen, rlast, exp_rd, exp_lcv;

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:8]);
  endfunction

  task automatic model_init();
    sq.delete(); dq.delete();
    par = 0; tlast = 0; rseen = 0; rlast = 0;
    exp_tp = 0; exp_tn = 0; exp_rd = 0; exp_lcv = 0;
    if (!cfg_nrz && !cfg_tx_ami) begin sq.push_back(0); zc = RUN - 1; end
    else begin for (int i = 0; i < RUN; i++) sq.push_back(0); zc = 0; end
    for (int i = 0; i < RUN; i++) dq.push_back(1'b0);
  endtask

  task automatic tx_model(input bit b);
    int s;
    s = sq.pop_front();
    if (cfg_nrz) begin exp_tp = (s != 0); exp_tn = 0; end
    else if (s == 0) begin exp_tp = 0; exp_tn = 0; end
    else if (s == 3) begin exp_tp = tlast; exp_tn = !tlast; end
    else begin exp_tp = !tlast; exp_tn = tlast; tlast = !tlast; end
    if (!cfg_nrz && !cfg_tx_ami) begin
      if (b) begin
        repeat (zc) sq.push_back(0);
        zc = 0; sq.push_back(1); par = !par;
      end else begin
        zc++;
        if (zc == RUN) begin
          sq.push_back(par ? 0 : 2);
          repeat (RUN - 2) sq.push_back(0);
          sq.push_back(3);
          zc = 0; par = 0;
        end
      end
    end else sq.push_back(b ? 1 : 0);
  endtask

  task automatic rx_model(input bit p, input bit n);
    bit same, quiet;
    exp_rd = dq.pop_front();
    exp_lcv = 0;
    if (cfg_nrz) begin dq.push_back(p); exp_lcv = n; end
    else if (p && n) begin dq.push_back(1); exp_lcv = 1; end
    else if (p || n) begin
      same = rseen && (p == rlast);
      quiet = 1;
      for (int i = 1; i <= RUN - 2; i++) if (dq[i]) quiet = 0;
      if (same && !cfg_rx_ami && quiet) begin
        for (int i = 0; i < dq.size(); i++) dq[i] = 0;
        dq.push_back(0);
      end else begin
        dq.push_back(1); exp_lcv = same;
      end
      rseen = 1; rlast = p;
    end else dq.push_back(0);
  endtask

  task automatic cyc(input bit te, input bit tb, input bit re,
                     input bit rp, input bit rn, input bit loop);
    bit p, n;
    @(negedge clk);
    tests++;
    if (tx_pos !== exp_tp || tx_neg !== exp_tn || rx_data !== exp_rd || rx_lcv_inc !== exp_lcv) begin
      fails++;
      $display("FAIL %s: actual pos=%b neg=%b data=%b lcv=%b expected pos=%b neg=%b data=%b lcv=%b",
               tag, tx_pos, tx_neg, rx_data, rx_lcv_inc, exp_tp, exp_tn, exp_rd, exp_lcv);
    end
    p = loop ? tx_pos : rp;
    n = loop ? tx_neg : rn;
    tx_en = te; tx_data = tb; rx_en = re; rx_pos = p; rx_neg = n;
    if (te) tx_model(tb);
    if (re) rx_model(p, n); else exp_lcv = 0;
  endtask

  task automatic do_reset(input bit ta, input bit ra, input bit nz);
    @(negedge clk);
    rst_n = 0; cfg_tx_ami = ta; cfg_rx_ami = ra; cfg_nrz = nz;
    tx_en = 0; rx_en = 0; tx_data = 0; rx_pos = 0; rx_neg = 0;
    model_init();
    tag = "R10";
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    rst_n = 1;
    repeat (4) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 0; cfg_tx_ami = 0; cfg_rx_ami = 0; cfg_nrz = 0;
    tx_en = 0; tx_data = 0; rx_en = 0; rx_pos = 0; rx_neg = 0;
    model_init();

    // R10 reset state, then R1 R2 R6 substitution loopback with sparse marks
    do_reset(0, 0, 0);
    tag = "R1 R2 R6";
    for (int k = 0; k < 800; k++) cyc(1, (rnd() % 4) == 0, 1, 0, 0, 1);

    // R3 and plain AMI receive, denser data
    do_reset(1, 1, 0);
    tag = "R3";
    for (int k = 0; k < 300; k++) cyc(1, (rnd() % 2) == 0, 1, 0, 0, 1);

    // R7: substituted stream into an AMI receiver flags each V
    do_reset(0, 1, 0);
    tag = "R7";
    for (int k = 0; k < 300; k++) cyc(1, (rnd() % 4) == 0, 1, 0, 0, 1);

    // R4 R5: NRZ bypass with AMI bits set (ignored)
    do_reset(1, 1, 1);
    tag = "R4 R5";
    for (int k = 0; k < 300; k++) begin
      int r = rnd();
      cyc(1, r[0], 1, r[1], r[2], 0);
    end

    // R8 R6: injected rail errors, then a valid B00V
    do_reset(0, 0, 0);
    tag = "R8 R6";
    cyc(0, 0, 1, 1, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0);
    cyc(0, 0, 1, 1, 1, 0);
    cyc(0, 0, 1, 0, 1, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 0);
    for (int k = 0; k < 400; k++) begin
      int r = rnd();
      cyc(0, 0, 1, (r % 5) == 0, (r % 7) == 0, 0);
    end

    // R9: enables with gaps in both directions
    do_reset(0, 0, 0);
    tag = "R9";
    for (int k = 0; k < 600; k++) begin
      int r = rnd();
      cyc((r % 3) != 0, (r[5:4] == 2'b00), (r[7:6] != 2'b00), 0, 0, 1);
    end
    cyc(0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule